// File: doc/BRIEF.md
# Indexed CMOS Configuration RAM with Clock Passthrough

The block places a two-register window in front of a 256-byte configuration store. The host sees two byte-wide locations, chosen by address bit 0. The even location holds a pointer, called the select register. The odd location reads or writes the byte that the pointer names. Pointer values at or below a boundary (0x0D by default) do not name a local byte. They name a register inside an external real-time-clock device. The block reaches that device through a small master port with a one-bit offset.

When the host writes a pointer value at or below the boundary, the block repeats that byte to the clock device's offset-0 (address) register. This keeps the device's own pointer in step with the local one. Data-port accesses under such a pointer go to the clock's offset-1 (data) register. Data-port accesses under any higher pointer use the local store. All host reads complete with the same fixed latency, whichever target serves them. There is no back-pressure on either side: every strobe is accepted in the cycle it is seen. A read result is presented once, as a single-cycle valid pulse that the host must capture.

Top module: `cmos_idx_window`

## Requirements
- R1: Address bit 0 low selects the index port and high selects the data port. A read of the index port returns the current select value.
- R2: A write to the index port stores all 8 bits of the written byte in the select register, including values above 0x0D such as 0xFF.
- R3: A write to the index port with a value of 0x0D or lower produces, in the following cycle, a one-cycle `rtc_wr` pulse with `rtc_addr`=0 and `rtc_wdata` equal to the written byte. A value above 0x0D produces no clock-side strobe.
- R4: A data-port write while select is 0x0D or lower produces, in the following cycle, a one-cycle `rtc_wr` pulse with `rtc_addr`=1 carrying the byte. The local store is not changed.
- R5: A data-port read while select is 0x0D or lower produces, in the following cycle, a one-cycle `rtc_rd` pulse with `rtc_addr`=1. The block samples `rtc_rdata` at the end of that pulse cycle and returns that byte to the host.
- R6: A data-port access while select is above 0x0D writes or reads the local byte indexed by select, and produces no clock-side strobe.
- R7: Reset clears the select register and every local byte to zero. With `CENTURY_PRESET`=1, byte 0x48 instead resets to 20 (0x14).
- R8: A host read strobe sampled at one rising edge yields `host_rvalid` high for exactly one cycle, after the second following rising edge, with `host_rdata` valid in that cycle. The latency is the same for every target.
- R9: When read and write strobes are both high in the same cycle, the access is handled as a write alone. No `rtc_rd` pulse and no `host_rvalid` pulse follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr0 | input | 1 | Window address bit: 0 index port, 1 data port |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read result, valid with host_rvalid |
| host_rvalid | output | 1 | One-cycle read completion pulse |
| rtc_addr | output | 1 | Clock device offset: 0 address register, 1 data register |
| rtc_rd | output | 1 | Clock device read strobe |
| rtc_wr | output | 1 | Clock device write strobe |
| rtc_wdata | output | 8 | Byte sent to the clock device |
| rtc_rdata | input | 8 | Byte returned by the clock device |

## Verification
The bench builds the block with `CENTURY_PRESET`=1 and the default boundary of 0x0D. This lets it confirm the preset byte at 0x48 after reset, next to zeroed neighbours. Pointer values 0x0D and 0x0E sit on either side of the routing boundary, and the bench drives them directly to check the switch between clock and store. A behavioural clock model in the bench keeps its own pointer. Values read through that model therefore also show that every index echo arrived with the right byte.

// File: rtl/cmos_win_pkg.sv
package cmos_win_pkg;
  // which source answers a pending host read
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_INDEX = 2'd1,
    SRC_CLOCK = 2'd2,
    SRC_STORE = 2'd3
  } rd_src_e;
endpackage

// File: rtl/cmos_index_decode.sv
module cmos_index_decode
  import cmos_win_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int RTC_LAST = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_addr0,
  input  logic             host_rd,
  input  logic             host_wr,
  input  logic [IDX_W-1:0] host_wdata,
  output logic [IDX_W-1:0] sel_q,
  output rd_src_e          rd_src,
  output logic             store_we,
  output logic             rtc_addr,
  output logic             rtc_rd,
  output logic             rtc_wr,
  output logic [IDX_W-1:0] rtc_wdata
);
  logic wr_go, rd_go, sel_low, wdat_low;

  // a write wins over a simultaneous read
  assign wr_go    = host_wr;
  assign rd_go    = host_rd & ~host_wr;
  assign sel_low  = (int'(sel_q) <= RTC_LAST);
  assign wdat_low = (int'(host_wdata) <= RTC_LAST);
  assign store_we = wr_go & host_addr0 & ~sel_low;

  always_comb begin
    if (!rd_go)           rd_src = SRC_NONE;
    else if (!host_addr0) rd_src = SRC_INDEX;
    else if (sel_low)     rd_src = SRC_CLOCK;
    else                  rd_src = SRC_STORE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q     <= '0;
      rtc_addr  <= 1'b0;
      rtc_rd    <= 1'b0;
      rtc_wr    <= 1'b0;
      rtc_wdata <= '0;
    end else begin
      rtc_rd <= rd_go & host_addr0 & sel_low;
      rtc_wr <= wr_go & (host_addr0 ? sel_low : wdat_low);
      if (wr_go) rtc_wdata <= host_wdata;
      if (wr_go || rd_go) rtc_addr <= host_addr0;
      if (wr_go && !host_addr0) sel_q <= host_wdata;
    end
  end
endmodule

// File: rtl/cmos_ram_store.sv
module cmos_ram_store #(
  parameter int          IDX_W          = 8,
  parameter int          DATA_W         = 8,
  parameter bit          CENTURY_PRESET = 1'b0,
  parameter int          CENTURY_IDX    = 8'h48,
  parameter int          CENTURY_VAL    = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata_q
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // per-byte storage so each cell carries its own reset value
  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    localparam logic [DATA_W-1:0] RST_VAL =
      (CENTURY_PRESET && g == CENTURY_IDX) ? DATA_W'(CENTURY_VAL) : '0;
    always_ff @(posedge clk) begin
      if (!rst_n)                                   mem[g] <= RST_VAL;
      else if (we && idx == IDX_W'(g))              mem[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= mem[idx];
  end
endmodule

// File: rtl/cmos_read_return.sv
module cmos_read_return
  import cmos_win_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rd_src_e           rd_src,
  input  logic [DATA_W-1:0] sel_now,
  input  logic [DATA_W-1:0] store_q,
  input  logic [DATA_W-1:0] clock_rdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid
);
  rd_src_e           src_q;
  logic [DATA_W-1:0] sel_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q       <= SRC_NONE;
      sel_d       <= '0;
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      src_q       <= rd_src;
      sel_d       <= sel_now;
      host_rvalid <= (src_q != SRC_NONE);
      unique case (src_q)
        SRC_INDEX: host_rdata <= sel_d;
        SRC_CLOCK: host_rdata <= clock_rdata;
        SRC_STORE: host_rdata <= store_q;
        default:   host_rdata <= host_rdata;
      endcase
    end
  end
endmodule

// File: rtl/cmos_idx_window.sv
module cmos_idx_window
  import cmos_win_pkg::*;
#(
  parameter int RTC_LAST       = 13,
  parameter bit CENTURY_PRESET = 1'b0,
  parameter int CENTURY_IDX    = 8'h48,
  parameter int CENTURY_VAL    = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_addr0,
  input  logic       host_rd,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       host_rvalid,
  output logic       rtc_addr,
  output logic       rtc_rd,
  output logic       rtc_wr,
  output logic [7:0] rtc_wdata,
  input  logic [7:0] rtc_rdata
);
  localparam int IDX_W  = 8;
  localparam int DATA_W = 8;

  logic [IDX_W-1:0]  sel_q;
  logic [DATA_W-1:0] store_q;
  logic              store_we;
  rd_src_e           rd_src;

  cmos_index_decode #(.IDX_W(IDX_W), .RTC_LAST(RTC_LAST)) u_dec (
    .clk(clk), .rst_n(rst_n), .host_addr0(host_addr0), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .sel_q(sel_q),
    .rd_src(rd_src), .store_we(store_we), .rtc_addr(rtc_addr),
    .rtc_rd(rtc_rd), .rtc_wr(rtc_wr), .rtc_wdata(rtc_wdata)
  );

  cmos_ram_store #(
    .IDX_W(IDX_W), .DATA_W(DATA_W), .CENTURY_PRESET(CENTURY_PRESET),
    .CENTURY_IDX(CENTURY_IDX), .CENTURY_VAL(CENTURY_VAL)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .we(store_we), .idx(sel_q),
    .wdata(host_wdata), .rdata_q(store_q)
  );

  cmos_read_return #(.DATA_W(DATA_W)) u_ret (
    .clk(clk), .rst_n(rst_n), .rd_src(rd_src), .sel_now(sel_q),
    .store_q(store_q), .clock_rdata(rtc_rdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid)
  );
endmodule

// File: rtl/cmos_idx_window_chk.sv
module cmos_idx_window_chk #(
  parameter int RTC_LAST = 13
) (
  input logic       clk,
  input logic       rst_n,
  input logic       host_addr0,
  input logic       host_rd,
  input logic       host_wr,
  input logic [7:0] host_wdata,
  input logic       host_rvalid,
  input logic       rtc_addr,
  input logic       rtc_rd,
  input logic       rtc_wr,
  input logic [7:0] rtc_wdata
);
  // R3: low index write is echoed to the clock address register
  p_index_echo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_addr0 && int'(host_wdata) <= RTC_LAST)
      |=> (rtc_wr && !rtc_addr && rtc_wdata == $past(host_wdata)));

  // R3: high index write stays local
  p_index_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_addr0 && int'(host_wdata) > RTC_LAST) |=> !rtc_wr);

  // R5: clock reads always target the data register
  p_clock_read_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_rd |-> (rtc_addr && !rtc_wr));

  // R5: clock read strobe lasts one cycle
  p_clock_read_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_rd |=> !rtc_rd || $past(host_rd && !host_wr));

  // R8: every read completes two edges later
  p_read_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr) |=> ##1 host_rvalid);

  // R9: a write-plus-read cycle never completes a read
  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> ##1 !host_rvalid || $past(host_rd && !host_wr));

  // R9: no clock read follows a write cycle
  p_write_no_crd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> !rtc_rd);
endmodule

bind cmos_idx_window cmos_idx_window_chk #(.RTC_LAST(RTC_LAST)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr0(host_addr0), .host_rd(host_rd),
  .host_wr(host_wr), .host_wdata(host_wdata), .host_rvalid(host_rvalid),
  .rtc_addr(rtc_addr), .rtc_rd(rtc_rd), .rtc_wr(rtc_wr), .rtc_wdata(rtc_wdata)
);

// File: tb/tb_cmos_idx_window.sv
module tb_cmos_idx_window;
  localparam int LAST = 13;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_addr0 = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       host_rvalid;
  logic       rtc_addr, rtc_rd, rtc_wr;
  logic [7:0] rtc_wdata, rtc_rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cmos_idx_window #(.RTC_LAST(LAST), .CENTURY_PRESET(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .host_addr0(host_addr0), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .rtc_addr(rtc_addr), .rtc_rd(rtc_rd),
    .rtc_wr(rtc_wr), .rtc_wdata(rtc_wdata), .rtc_rdata(rtc_rdata)
  );

  // behavioural clock device with its own pointer
  logic [7:0] dev_ptr;
  logic [7:0] dev_reg [16];
  function automatic logic [7:0] dev_init(int i);
    return 8'hA0 + 8'(i * 3);
  endfunction
  always @(posedge clk) begin
    if (!rst_n) begin
      dev_ptr <= '0;
      for (int i = 0; i < 16; i++) dev_reg[i] <= dev_init(i);
    end else if (rtc_wr) begin
      if (!rtc_addr) dev_ptr <= rtc_wdata;
      else           dev_reg[dev_ptr[3:0]] <= rtc_wdata;
    end
  end
  assign rtc_rdata = dev_reg[dev_ptr[3:0]];

  // expected state
  logic [7:0] e_sel;
  logic [7:0] e_ram [256];
  logic [7:0] e_dev [16];

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(bit a);
    if (!a) return e_sel;
    if (int'(e_sel) <= LAST) return e_dev[e_sel[3:0]];
    return e_ram[e_sel];
  endfunction

  // write, optionally with a simultaneous read strobe (R9)
  task automatic do_write(input bit a, input logic [7:0] v, input bit with_rd);
    bit low_sel;
    low_sel = int'(e_sel) <= LAST;
    @(negedge clk);
    host_addr0 = a; host_wdata = v; host_wr = 1'b1; host_rd = with_rd;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0;
    if (!a) begin
      if (int'(v) <= LAST)  // R3 echo
        chk(rtc_wr && !rtc_addr && rtc_wdata == v && !rtc_rd, "R3 index echo", rtc_wdata, v);
      else
        chk(!rtc_wr && !rtc_rd, "R3 no echo above boundary", {7'd0, rtc_wr}, 8'd0);
      e_sel = v;
    end else if (low_sel) begin
      chk(rtc_wr && rtc_addr && rtc_wdata == v && !rtc_rd, "R4 clock data write", rtc_wdata, v);
      e_dev[e_sel[3:0]] = v;
    end else begin
      chk(!rtc_wr && !rtc_rd, "R6 store write no strobe", {6'd0, rtc_rd, rtc_wr}, 8'd0);
      e_ram[e_sel] = v;
    end
    @(negedge clk);
    if (with_rd)
      chk(!host_rvalid, "R9 write wins, no rvalid", {7'd0, host_rvalid}, 8'd0);
  endtask

  task automatic do_read(input bit a, input string req);
    bit to_clk;
    logic [7:0] e;
    to_clk = a && int'(e_sel) <= LAST;
    e = exp_read(a);
    @(negedge clk);
    host_addr0 = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    chk(rtc_rd == to_clk && (!to_clk || rtc_addr) && !host_rvalid,
        "R5/R8 clock strobe and no early rvalid", {6'd0, rtc_rd, host_rvalid}, {6'd0, to_clk, 1'b0});
    @(negedge clk);
    chk(host_rvalid && host_rdata == e, req, host_rdata, e);
    @(negedge clk);
    chk(!host_rvalid, "R8 single rvalid pulse", {7'd0, host_rvalid}, 8'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0_FFEE));
    e_sel = '0;
    for (int i = 0; i < 256; i++) e_ram[i] = '0;
    e_ram[8'h48] = 8'd20;
    for (int i = 0; i < 16; i++) e_dev[i] = dev_init(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R7 reset state
    do_read(1'b0, "R7 select resets to 0");
    do_read(1'b1, "R5 clock read of register 0");
    do_write(1'b0, 8'h48, 1'b0);
    do_read(1'b1, "R7 century preset 20");
    do_write(1'b0, 8'h47, 1'b0);
    do_read(1'b1, "R7 neighbour cleared");
    do_write(1'b0, 8'hFF, 1'b0);
    do_read(1'b0, "R2 full byte select FF");
    do_read(1'b1, "R7 top byte cleared");
    // boundary 0x0D / 0x0E
    do_write(1'b0, 8'h0D, 1'b0);
    do_write(1'b1, 8'h5A, 1'b0);
    do_read(1'b1, "R4/R5 clock register 0D round trip");
    do_write(1'b0, 8'h0E, 1'b0);
    do_read(1'b1, "R7 byte 0E cleared");
    do_write(1'b1, 8'hC3, 1'b0);
    do_read(1'b1, "R6 store byte 0E");
    do_read(1'b0, "R1 index port returns 0E");
    // R9 simultaneous strobes
    do_write(1'b1, 8'h3C, 1'b1);
    do_read(1'b1, "R9 write taken from combined strobe");
    do_write(1'b0, 8'h02, 1'b1);
    do_read(1'b1, "R9 echo from combined index strobe");

    // constrained random mix
    for (int k = 0; k < 400; k++) begin
      int op;
      logic [7:0] v;
      op = int'($urandom_range(0, 9));
      v  = ($urandom_range(0, 1) == 0) ? 8'($urandom_range(0, 31)) : 8'($urandom);
      case (op)
        0, 1:    do_write(1'b0, v, 1'b0);
        2, 3, 4: do_write(1'b1, v, 1'b0);
        5:       do_write(1'b1, v, 1'b1);
        6:       do_read(1'b0, "R1 random index read");
        default: do_read(1'b1, "R6/R5 random data read");
      endcase
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule